// File: doc/BRIEF.md
# Destination-Paced DMA Channel

This block is one channel of a DMA engine that carries 32-bit words from a source peripheral to a destination peripheral through an 8-word internal FIFO. Both peripherals talk to the channel over a hardware request/acknowledge handshake. Each side has a burst request and a single request. The destination side also has a flag that marks its final transaction. The channel never knows the block length in advance: the destination paces the block and ends it by marking one of its transactions as the last.

A mode input chooses how the source side is fed. In prefetch mode the channel reads ahead from the source and keeps the FIFO full, whether or not the destination is asking for data. If the block then ends with words still in the FIFO, those words are dropped and counted, because a read-sensitive source cannot supply them again. In demand mode the channel reads from the source only the words that a pending destination transaction still lacks, so nothing is ever dropped.

After the destination's final transaction is acknowledged, the channel pulses a done output, flushes the FIFO and returns to idle until the next start.

Top module: `dma_dstfc_channel`

## Requirements
- R1: After reset, blk_done, src_ack, dst_ack, src_rd and dst_wr are low, and fifo_level and drop_count are 0.
- R2: With prefetch_off=0 and no destination request pending, a source burst request (src_breq) is served by moving 8 words into the FIFO. The FIFO holds 8 words, and no word is written while it is full.
- R3: Suppose the last destination transaction (dst_last=1) is captured while the FIFO already holds enough words to finish it. The channel then takes no further source words. At block end the leftover words are dropped, and drop_count grows by exactly that number.
- R4: Suppose the FIFO holds too few words when the last destination transaction is captured. The channel then fetches exactly the missing words, and no more, even if a source burst is already in progress.
- R5: The words still needed are the words owed by the current destination transaction minus fifo_level. When this number is below 8 and either the last transaction is known or prefetch_off=1, source burst requests are ignored and each source single request (src_sreq) moves exactly one word.
- R6: With prefetch_off=1, no source word is fetched unless a destination request is pending. The words fetched for a block equal the block length, and drop_count does not change.
- R7: A request stays asserted until its acknowledge. Each acknowledge lasts one cycle and comes in the cycle after the transaction's last data word moves. On the destination side, dst_breq takes priority over dst_sreq. A destination burst moves 4 words and a single moves 1.
- R8: blk_done is high for exactly one cycle, the cycle after dst_ack of the last transaction. In the next cycle fifo_level is 0. No word moves again until enable is raised.
- R9: The destination receives the words in the order the source gave them, with no repeats or gaps, and the channel never reads from an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Starts a block when the channel is idle |
| prefetch_off | input | 1 | 0 = prefetch mode, 1 = demand-only fetching |
| src_breq | input | 1 | Source burst request (8 words) |
| src_sreq | input | 1 | Source single request (1 word) |
| src_data | input | 32 | Source data word, taken when src_rd is high |
| src_rd | output | 1 | A source word is taken at this clock edge |
| src_ack | output | 1 | One-cycle source acknowledge |
| dst_breq | input | 1 | Destination burst request (4 words) |
| dst_sreq | input | 1 | Destination single request (1 word) |
| dst_last | input | 1 | The current destination request is the block's last |
| dst_data | output | 32 | Word presented to the destination |
| dst_wr | output | 1 | dst_data is delivered at this clock edge |
| dst_ack | output | 1 | One-cycle destination acknowledge |
| blk_done | output | 1 | One-cycle block completion pulse |
| fifo_level | output | 4 | Words held in the channel FIFO |
| drop_count | output | 16 | Running count of prefetched words dropped |

## Verification
The two functions that share a clock edge are source writes into the FIFO and destination reads out of it. At that edge the outstanding need reaches one, and the channel must decide whether to take one more source word. The bench provokes this by raising a source burst request and a last destination request on the same edge. It judges the result by requiring that the words fetched equal the block length and that nothing is dropped. The bench also lets the block's done pulse fall while a source transaction is still open, then checks that the flush empties the FIFO and adds exactly the leftover count to drop_count.

// File: rtl/dmafc_pkg.sv
// Package: shared state encodings for the destination-paced DMA channel.
// Assumes: nothing beyond 2-state enum encodings.
package dmafc_pkg;
    typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_DONE} phase_t;
    typedef enum logic [1:0] {SE_IDLE, SE_MOVE, SE_ACK}  src_st_t;
    typedef enum logic [1:0] {DE_IDLE, DE_MOVE, DE_ACK}  dst_st_t;
endpackage

// File: rtl/dmafc_fifo.sv
// Module: dmafc_fifo. Synchronous FIFO with level output and a flush that empties it.
// Assumes: the caller never pushes when full or pops when empty; push and pop may coincide.
module dmafc_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Pointer and level upkeep with synchronous reset and flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Status and head-of-queue output.
    always_comb begin
        rdata = mem[rd_ptr];
        full  = (level == LVL_W'(DEPTH));
        empty = (level == '0);
    end
endmodule

// File: rtl/dmafc_src_engine.sv
// Module: dmafc_src_engine. Serves source handshake requests, one word per cycle into the FIFO.
// Assumes: need_pos/need_one/single_region come from the channel's need arithmetic; when
// 'limited' is high a transaction is cut short as soon as the outstanding need is met.
module dmafc_src_engine
    import dmafc_pkg::*;
#(
    parameter int SRC_BURST = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic limited,
    input  logic need_pos,
    input  logic need_one,
    input  logic single_region,
    input  logic full,
    input  logic breq,
    input  logic sreq,
    output logic rd,
    output logic ack
);
    localparam int CNT_W = $clog2(SRC_BURST + 1);

    src_st_t          st;
    logic [CNT_W-1:0] remain;
    logic             may_fetch;

    // Fetch permission and handshake outputs.
    always_comb begin
        may_fetch = run && (!limited || need_pos);
        rd        = (st == SE_MOVE) && may_fetch && !full;
        ack       = (st == SE_ACK);
    end

    // Transaction sequencing: pick length, move words, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            st     <= SE_IDLE;
            remain <= '0;
        end else begin
            case (st)
                SE_IDLE: if (may_fetch) begin
                    if (breq && !single_region) begin
                        remain <= CNT_W'(SRC_BURST);
                        st     <= SE_MOVE;
                    end else if (sreq) begin
                        remain <= CNT_W'(1);
                        st     <= SE_MOVE;
                    end
                end
                SE_MOVE: begin
                    if (rd) begin
                        remain <= remain - 1'b1;
                        if (remain == CNT_W'(1) || (limited && need_one)) st <= SE_ACK;
                    end else if (run && limited && !need_pos) begin
                        st <= SE_ACK;
                    end
                end
                default: st <= SE_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dmafc_dst_engine.sv
// Module: dmafc_dst_engine. Serves destination handshake requests out of the FIFO and
// tracks the words owed to the current destination transaction and whether the last one is known.
// Assumes: burst has priority over single; no new transaction is accepted after the last one.
module dmafc_dst_engine
    import dmafc_pkg::*;
#(
    parameter int DST_BURST = 4,
    parameter int OWE_W     = $clog2(DST_BURST + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             breq,
    input  logic             sreq,
    input  logic             last,
    input  logic             empty,
    output logic             pop,
    output logic             ack,
    output logic [OWE_W-1:0] owed,
    output logic             last_known,
    output logic             last_done
);
    dst_st_t st;
    logic    cur_last;

    // Delivery strobe and handshake outputs.
    always_comb begin
        pop       = (st == DE_MOVE) && !empty;
        ack       = (st == DE_ACK);
        last_done = ack && cur_last;
    end

    // Transaction capture, delivery count-down and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            st         <= DE_IDLE;
            owed       <= '0;
            cur_last   <= 1'b0;
            last_known <= 1'b0;
        end else begin
            case (st)
                DE_IDLE: if (run && !last_known && (breq || sreq)) begin
                    owed       <= breq ? OWE_W'(DST_BURST) : OWE_W'(1);
                    cur_last   <= last;
                    last_known <= last;
                    st         <= DE_MOVE;
                end
                DE_MOVE: if (pop) begin
                    owed <= owed - 1'b1;
                    if (owed == OWE_W'(1)) st <= DE_ACK;
                end
                default: st <= DE_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_dstfc_channel.sv
// Module: dma_dstfc_channel. One DMA channel whose block length is set by the destination.
// Prefetch mode keeps the FIFO full and drops surplus at block end; demand mode fetches only
// what a pending destination transaction lacks. Assumes DST_BURST <= FIFO_DEPTH.
module dma_dstfc_channel
    import dmafc_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 8,
    parameter int SRC_BURST  = 8,
    parameter int DST_BURST  = 4,
    parameter int CNT_W      = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            enable,
    input  logic                            prefetch_off,
    input  logic                            src_breq,
    input  logic                            src_sreq,
    input  logic [DATA_W-1:0]               src_data,
    output logic                            src_rd,
    output logic                            src_ack,
    input  logic                            dst_breq,
    input  logic                            dst_sreq,
    input  logic                            dst_last,
    output logic [DATA_W-1:0]               dst_data,
    output logic                            dst_wr,
    output logic                            dst_ack,
    output logic                            blk_done,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
    output logic [CNT_W-1:0]                drop_count
);
    localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);
    localparam int OWE_W  = $clog2(DST_BURST + 1);
    localparam int NEED_W = LVL_W + 2;

    phase_t                    phase;
    logic                      run, flush, full, empty;
    logic                      last_known, last_done, limited;
    logic [OWE_W-1:0]          owed;
    logic signed [NEED_W-1:0]  need;
    logic                      need_pos, need_one, single_region;

    // Block phase: idle -> running -> one done cycle -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE: if (enable)    phase <= PH_RUN;
                PH_RUN:  if (last_done) phase <= PH_DONE;
                default:                phase <= PH_IDLE;
            endcase
        end
    end

    // Dropped-word tally, taken as the FIFO is flushed.
    always_ff @(posedge clk) begin
        if (!rst_n)                 drop_count <= '0;
        else if (phase == PH_DONE)  drop_count <= drop_count + CNT_W'(fifo_level);
    end

    // Outstanding-need arithmetic steering the source side.
    always_comb begin
        run           = (phase == PH_RUN);
        flush         = (phase == PH_DONE);
        blk_done      = flush;
        limited       = prefetch_off || last_known;
        need          = $signed(NEED_W'(owed)) - $signed(NEED_W'(fifo_level));
        need_pos      = (need > 0);
        need_one      = (need == 1);
        single_region = limited && (need < $signed(NEED_W'(SRC_BURST)));
    end

    dmafc_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (src_rd),
        .wdata (src_data),
        .pop   (dst_wr),
        .rdata (dst_data),
        .level (fifo_level),
        .full  (full),
        .empty (empty)
    );

    dmafc_src_engine #(.SRC_BURST(SRC_BURST)) u_src (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (flush),
        .run           (run),
        .limited       (limited),
        .need_pos      (need_pos),
        .need_one      (need_one),
        .single_region (single_region),
        .full          (full),
        .breq          (src_breq),
        .sreq          (src_sreq),
        .rd            (src_rd),
        .ack           (src_ack)
    );

    dmafc_dst_engine #(.DST_BURST(DST_BURST), .OWE_W(OWE_W)) u_dst (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (flush),
        .run        (run),
        .breq       (dst_breq),
        .sreq       (dst_sreq),
        .last       (dst_last),
        .empty      (empty),
        .pop        (dst_wr),
        .ack        (dst_ack),
        .owed       (owed),
        .last_known (last_known),
        .last_done  (last_done)
    );
endmodule

// File: rtl/dmafc_checker.sv
// Module: dmafc_checker. Port-level temporal checks for dma_dstfc_channel, attached by bind.
// Assumes: reset is applied before the first meaningful clock edge.
module dmafc_checker #(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prefetch_off,
    input logic             src_rd,
    input logic             src_ack,
    input logic             dst_breq,
    input logic             dst_sreq,
    input logic             dst_wr,
    input logic             dst_ack,
    input logic             blk_done,
    input logic [LVL_W-1:0] fifo_level,
    input logic [CNT_W-1:0] drop_count
);
    // R2: no source word is written into a full FIFO.
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd |-> (fifo_level < LVL_W'(DEPTH)));

    // R9: no delivery from an empty FIFO.
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dst_wr |-> (fifo_level != '0));

    // R7: source acknowledge lasts one cycle.
    assert_src_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        src_ack |=> !src_ack);

    // R7: destination acknowledge follows the cycle of a data move.
    assert_dst_ack_after_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dst_ack |-> $past(dst_wr));

    // R8: done is one cycle and leaves an empty FIFO.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> (!blk_done && fifo_level == '0));

    // R6: demand mode fetches only against a pending destination request.
    assert_demand_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prefetch_off && src_rd) |-> (dst_breq || dst_sreq));

    // R6: demand mode never adds to the drop tally.
    assert_demand_nodrop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prefetch_off && blk_done) |=> $stable(drop_count));
endmodule

bind dma_dstfc_channel dmafc_checker #(
    .DEPTH (FIFO_DEPTH),
    .LVL_W ($clog2(FIFO_DEPTH + 1)),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .prefetch_off (prefetch_off),
    .src_rd       (src_rd),
    .src_ack      (src_ack),
    .dst_breq     (dst_breq),
    .dst_sreq     (dst_sreq),
    .dst_wr       (dst_wr),
    .dst_ack      (dst_ack),
    .blk_done     (blk_done),
    .fifo_level   (fifo_level),
    .drop_count   (drop_count)
);

// File: tb/sim_dma_dstfc_channel.sv
`timescale 1ns/1ps
module sim_dma_dstfc_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, prefetch_off = 1'b0;
    logic        src_breq = 1'b0, src_sreq = 1'b0;
    logic [31:0] src_data = '0;
    logic        src_rd, src_ack;
    logic        dst_breq = 1'b0, dst_sreq = 1'b0, dst_last = 1'b0;
    logic [31:0] dst_data;
    logic        dst_wr, dst_ack, blk_done;
    logic [3:0]  fifo_level;
    logic [15:0] drop_count;

    int checks = 0, fails = 0;
    int fetched = 0, delivered = 0, block_base = 0, txn_words = 0, src_acks = 0;
    int src_budget = 0;
    bit offer_burst = 1'b1, offer_single = 1'b1;

    always #10 clk = ~clk;

    dma_dstfc_channel u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .prefetch_off(prefetch_off),
        .src_breq(src_breq), .src_sreq(src_sreq), .src_data(src_data),
        .src_rd(src_rd), .src_ack(src_ack),
        .dst_breq(dst_breq), .dst_sreq(dst_sreq), .dst_last(dst_last),
        .dst_data(dst_data), .dst_wr(dst_wr), .dst_ack(dst_ack),
        .blk_done(blk_done), .fifo_level(fifo_level), .drop_count(drop_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Source peripheral model: word k carries value k; requests dropped on acknowledge.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (src_ack) begin
                    src_breq = 1'b0; src_sreq = 1'b0; src_acks++;
                end else if (!src_breq && !src_sreq && src_budget > 0) begin
                    src_breq = offer_burst; src_sreq = offer_single; src_budget--;
                end
                if (src_rd) begin
                    fetched++;
                    @(posedge clk);
                    #1 src_data = 32'(fetched);
                end
            end
        end
    end

    // Destination monitor: order and count of delivered words (R9).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && dst_wr) begin
                check(dst_data == 32'(block_base + delivered), "R9 order", int'(dst_data), block_base + delivered);
                delivered++;
                txn_words++;
            end
        end
    end

    task automatic dst_txn(input bit burst, input bit last);
        @(negedge clk);
        dst_breq = burst; dst_sreq = !burst; dst_last = last; txn_words = 0;
        do @(negedge clk); while (!dst_ack);
        dst_breq = 1'b0; dst_sreq = 1'b0; dst_last = 1'b0;
        check(txn_words == (burst ? 4 : 1), "R7 words per dst txn", txn_words, burst ? 4 : 1);
    endtask

    task automatic start_block(input bit mode);
        @(negedge clk);
        prefetch_off = mode; block_base = fetched; delivered = 0;
        enable = 1'b1;
        @(negedge clk);
        enable = 1'b0;
    endtask

    // Called at the negedge where the last dst_ack was seen.
    task automatic finish_block(input int len, input int drop_before, input int exp_drop);
        @(negedge clk);
        check(blk_done == 1'b1, "R8 done after last ack", int'(blk_done), 1);
        src_budget = 0; src_breq = 1'b0; src_sreq = 1'b0;
        @(negedge clk);
        check(blk_done == 1'b0, "R8 done one cycle", int'(blk_done), 0);
        check(fifo_level == 0, "R8 flushed", int'(fifo_level), 0);
        check(delivered == len, "R9 delivered count", delivered, len);
        check(int'(drop_count) == drop_before + exp_drop, "R3 drop tally", int'(drop_count), drop_before + exp_drop);
    endtask

    // Free-running source; dst does nb bursts then a final burst or single.
    task automatic sweep_block(input bit mode, input int nb, input bit fin_burst);
        int len, d0, got;
        len = nb * 4 + (fin_burst ? 4 : 1);
        d0 = int'(drop_count);
        offer_burst = 1'b1; offer_single = 1'b1; src_budget = 1000;
        start_block(mode);
        repeat (16) @(negedge clk);
        if (mode) check(fetched == block_base, "R6 no fetch without dst request", fetched - block_base, 0);
        else      check(fifo_level == 8, "R2 prefetch fills FIFO", int'(fifo_level), 8);
        for (int i = 0; i < nb; i++) dst_txn(1'b1, 1'b0);
        dst_txn(fin_burst, 1'b1);
        finish_block(len, d0, fetched - block_base - len);
        got = fetched - block_base;
        if (mode) check(got == len, "R6 fetched equals length", got, len);
        else      check(got >= len && got - len <= 8, "R3 surplus bounded", got - len, 8);
    endtask

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        check(!blk_done && !src_ack && !dst_ack, "R1 handshakes low", int'({blk_done, src_ack, dst_ack}), 0);
        check(!src_rd && !dst_wr, "R1 strobes low", int'({src_rd, dst_wr}), 0);
        check(fifo_level == 0, "R1 level", int'(fifo_level), 0);
        check(drop_count == 0, "R1 drop count", int'(drop_count), 0);
        rst_n = 1'b1;

        // R8: no movement before enable even with source asking.
        src_budget = 1;
        repeat (10) @(negedge clk);
        check(fetched == 0 && fifo_level == 0, "R8 idle until enable", fetched, 0);
        src_budget = 0; src_breq = 1'b0; src_sreq = 1'b0;

        // R2/R3: one source burst prefetched, then a short block; exact surplus dropped.
        for (int lv = 0; lv < 2; lv++) begin
            d0 = int'(drop_count);
            start_block(1'b0);
            src_budget = 1;
            repeat (20) @(negedge clk);
            check(fifo_level == 8 && fetched - block_base == 8, "R2 burst of 8 held", int'(fifo_level), 8);
            check(src_breq == 1'b0 && src_acks > 0, "R7 source acked and released", int'(src_breq), 0);
            if (lv == 1) dst_txn(1'b1, 1'b0);
            dst_txn(1'b0, 1'b1);
            check(fetched - block_base == 8, "R3 no fetch after last known", fetched - block_base, 8);
            finish_block(lv == 1 ? 5 : 1, d0, lv == 1 ? 3 : 7);
        end

        // R4: last request raised on the same edge as a source burst; exact fetch.
        for (int fb = 0; fb < 2; fb++) begin
            d0 = int'(drop_count);
            start_block(1'b0);
            dst_breq = fb[0]; dst_sreq = !fb[0]; dst_last = 1'b1; txn_words = 0;
            src_breq = 1'b1; src_sreq = 1'b1;
            do @(negedge clk); while (!dst_ack);
            dst_breq = 1'b0; dst_sreq = 1'b0; dst_last = 1'b0;
            check(fetched - block_base == (fb ? 4 : 1), "R4 exact fetch", fetched - block_base, fb ? 4 : 1);
            finish_block(fb ? 4 : 1, d0, 0);
        end

        // R5: last known, need 4 < 8: burst request ignored, singles move one word each.
        d0 = int'(drop_count);
        start_block(1'b0);
        fork
            dst_txn(1'b1, 1'b1);
            begin
                repeat (3) @(negedge clk);
                src_breq = 1'b1;
                repeat (20) @(negedge clk);
                check(fetched == block_base && fifo_level == 0, "R5 burst ignored in single region", fetched - block_base, 0);
                src_acks = 0;
                offer_burst = 1'b1; offer_single = 1'b1; src_budget = 10;
                src_sreq = 1'b1;
            end
        join
        check(src_acks == 4 || src_acks == 3, "R5 one word per single", src_acks, 4);
        finish_block(4, d0, 0);
        check(fetched - block_base == 4, "R5 exact singles", fetched - block_base, 4);

        // Sweep both modes over block shapes.
        for (int m = 0; m < 2; m++)
            for (int nb = 0; nb < 3; nb++)
                for (int fb = 0; fb < 2; fb++)
                    sweep_block(m[0], nb, fb[0]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule